// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block turns the system clock into the bit-level timing of a CAN controller. A configuration word supplies a baud-rate prescaler, two phase-segment fields, a resynchronization jump width and a sample-mode flag. The prescaler divides the clock into time quanta of 2 × (prescaler + 1) clocks. Each bit is then walked through a one-quantum synchronization segment, a first phase segment of (field + 1) quanta and a second phase segment of (field + 1) quanta. The nominal bit therefore lasts 3 + seg1 + seg2 quanta.

The receive input passes through a two-flop synchronizer. A recessive-to-dominant edge seen while the bus is busy stretches the first phase or trims the second, by at most jump width + 1 quanta, and only once per bit. The same edge while the bus is idle restarts the bit at once. The block emits a transmit-point strobe at each bit start and a sample strobe at the sample point, together with the sampled bit. Settings outside the legal range raise an error flag and keep the timing idle.

Top module: `can_bit_timer`

## Requirements
- R1: One quantum lasts 2 × (cfg_brp + 1) clocks, and consecutive tx_stb pulses are (3 + cfg_tseg1 + cfg_tseg2) quanta apart. With cfg_brp=0, cfg_tseg1=4 and cfg_tseg2=3 a bit is 20 clocks. The settings 3/2 give 16 clocks and 15/7 give 50 clocks.
- R2: sample_stb pulses (cfg_tseg1 + 2) quanta after tx_stb when no edge occurs. In that cycle seg_o reads 2. seg_o encodes 0 as synchronization, 1 as first phase and 2 as second phase.
- R3: config_error is 1 exactly when any of these holds: cfg_tseg1 < 3, cfg_tseg1 ≤ cfg_tseg2, cfg_tseg2 = 0, cfg_sjw > cfg_tseg2, or cfg_tseg2 = 1 with cfg_brp = 0. While it is 1, neither strobe pulses and seg_o stays 0.
- R4: A falling synchronized edge during quantum q (counted from 0) of the first phase, with bus_idle low, lengthens that bit by min(q + 1, cfg_sjw + 1) quanta.
- R5: A falling synchronized edge during quantum q of the second phase, with bus_idle low, shortens that bit by min(cfg_tseg2 − q, cfg_sjw + 1) quanta.
- R6: A rising edge on rx_raw leaves the bit length unchanged. Only the first falling edge in a bit adjusts it.
- R7: With bus_idle high, a falling edge driven on rx_raw restarts the bit. sample_stb then follows 3 + 2 × (cfg_brp + 1) × (cfg_tseg1 + 2) clocks after the drive, with no tx_stb in between.
- R8: With cfg_triple low, rx_bit is the synchronized input at the sample point. With cfg_triple high, rx_bit is the majority of the samples taken at the ends of the last three quanta before the sample point. rx_bit updates in the same cycle as sample_stb.
- R9: After reset, tx_stb and sample_stb are 0, rx_bit is 1 and seg_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_brp | input | 6 | Baud-rate prescaler field |
| cfg_tseg1 | input | 4 | First phase field (length minus one) |
| cfg_tseg2 | input | 3 | Second phase field (length minus one) |
| cfg_sjw | input | 2 | Jump width field (limit minus one) |
| cfg_triple | input | 1 | 1 selects three-sample majority |
| bus_idle | input | 1 | High while no frame is in progress |
| rx_raw | input | 1 | Asynchronous receive line, 1 recessive |
| tq_tick | output | 1 | One-clock pulse ending each quantum |
| sample_stb | output | 1 | Sample point pulse |
| tx_stb | output | 1 | Bit start (transmit point) pulse |
| rx_bit | output | 1 | Value taken at the last sample point |
| seg_o | output | 2 | Current segment code |
| config_error | output | 1 | Illegal configuration flag |

## Verification
Bit periods are measured between transmit strobes. This is done on an undisturbed line, at the smallest and largest legal bit lengths, and with single falling edges placed in chosen quanta of each phase. Early and late edges near and beyond the jump width tell clamping apart from the raw phase error. A rising edge and a second falling edge in the same bit check that neither of them adjusts the timing. A one-quantum recessive glitch ending at the sample point separates single from majority sampling. Each forbidden field combination, and its permitted neighbour, checks the error decode and the idle hold.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_PH1  = 2'd1,
        SEG_PH2  = 2'd2
    } seg_e;

    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/can_bt_cfg_check.sv
module can_bt_cfg_check #(
    parameter int BRP_W = 6,
    parameter int T1_W  = 4,
    parameter int T2_W  = 3,
    parameter int SJW_W = 2
) (
    input  logic [BRP_W-1:0] brp,
    input  logic [T1_W-1:0]  tseg1,
    input  logic [T2_W-1:0]  tseg2,
    input  logic [SJW_W-1:0] sjw,
    output logic             bad
);
    localparam int CW = T1_W + T2_W + SJW_W;

    logic [CW-1:0] e1, e2, ej;
    logic t1_short, order_bad, t2_zero, sjw_bad, fast_bad;

    always_comb begin
        e1        = CW'(tseg1);
        e2        = CW'(tseg2);
        ej        = CW'(sjw);
        t1_short  = e1 < CW'(3);
        order_bad = e1 <= e2;
        t2_zero   = e2 == '0;
        sjw_bad   = ej > e2;
        fast_bad  = (e2 == CW'(1)) && (brp == '0);
        bad       = t1_short | order_bad | t2_zero | sjw_bad | fast_bad;
    end

endmodule

// File: rtl/can_bt_prescaler.sv
module can_bt_prescaler #(
    parameter int BRP_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BRP_W-1:0] brp,
    input  logic             hold,
    input  logic             restart,
    output logic             tq_tick
);
    localparam int CNT_W = BRP_W + 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] last;

    always_comb begin
        last    = {brp, 1'b1};
        tq_tick = !hold && (cnt_q >= last);
        if (hold || restart || tq_tick) cnt_d = '0;
        else                            cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // quanta last at least two clocks
    assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tq_tick |=> !tq_tick);

endmodule

// File: rtl/can_bt_rx_sync.sv
module can_bt_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_raw,
    output logic rx_s,
    output logic rx_fall
);
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d    = {sh_q[STAGES-1:0], rx_raw};
        rx_s    = sh_q[STAGES-1];
        rx_fall = sh_q[STAGES] & ~sh_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assert_single_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_fall |=> !rx_fall);

endmodule

// File: rtl/can_bt_sequencer.sv
module can_bt_sequencer
    import can_bt_pkg::*;
#(
    parameter int T1_W  = 4,
    parameter int T2_W  = 3,
    parameter int SJW_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tq_tick,
    input  logic             hold,
    input  logic             hsync,
    input  logic             rx_s,
    input  logic             rx_fall,
    input  logic [T1_W-1:0]  tseg1,
    input  logic [T2_W-1:0]  tseg2,
    input  logic [SJW_W-1:0] sjw,
    input  logic             triple,
    output logic             tx_stb,
    output logic             smp_stb,
    output logic             rx_bit,
    output logic [1:0]       seg
);
    localparam int QW = T1_W + 2;

    typedef struct packed {
        seg_e             seg;
        logic [QW-1:0]    qcnt;
        logic [SJW_W:0]   ext;
        logic [SJW_W:0]   shr;
        logic             done;
        logic             pend;
        logic [1:0]       hist;
        logic             rxb;
        logic             tx;
        logic             smp;
    } st_t;

    localparam st_t ST_RST = '{seg: SEG_SYNC, qcnt: '0, ext: '0, shr: '0,
                               done: 1'b0, pend: 1'b0, hist: 2'b11,
                               rxb: 1'b1, tx: 1'b0, smp: 1'b0};

    st_t st_d, st_q;
    logic [QW-1:0] len1, len2, adj_max, late, rem, ext_w, shr_w;
    logic          edge_now;

    always_comb begin
        st_d        = st_q;
        st_d.tx     = 1'b0;
        st_d.smp    = 1'b0;
        len1        = QW'(tseg1) + QW'(1);
        len2        = QW'(tseg2) + QW'(1);
        adj_max     = QW'(sjw) + QW'(1);
        late        = st_q.qcnt + QW'(1);
        rem         = len2 - st_q.qcnt - QW'(1);
        ext_w       = QW'(st_q.ext);
        shr_w       = QW'(st_q.shr);
        edge_now    = st_q.pend | rx_fall;

        if (hold) begin
            st_d = ST_RST;
        end else if (hsync) begin
            st_d      = ST_RST;
            st_d.done = 1'b1;
            st_d.hist = st_q.hist;
            st_d.rxb  = st_q.rxb;
        end else if (!tq_tick) begin
            st_d.pend = st_q.pend | rx_fall;
        end else begin
            st_d.pend = 1'b0;
            st_d.hist = {st_q.hist[0], rx_s};
            unique case (st_q.seg)
                SEG_SYNC: begin
                    st_d.seg  = SEG_PH1;
                    st_d.qcnt = '0;
                    if (edge_now) st_d.done = 1'b1;
                end
                SEG_PH1: begin
                    if (edge_now && !st_q.done) begin
                        ext_w     = (late < adj_max) ? late : adj_max;
                        st_d.done = 1'b1;
                    end
                    st_d.ext = ext_w[SJW_W:0];
                    if (late >= len1 + ext_w) begin
                        st_d.seg  = SEG_PH2;
                        st_d.qcnt = '0;
                        st_d.smp  = 1'b1;
                        st_d.rxb  = triple ? vote3(st_q.hist[1], st_q.hist[0], rx_s) : rx_s;
                    end else begin
                        st_d.qcnt = late;
                    end
                end
                SEG_PH2: begin
                    if (edge_now && !st_q.done) begin
                        shr_w     = (rem < adj_max) ? rem : adj_max;
                        st_d.done = 1'b1;
                    end
                    st_d.shr = shr_w[SJW_W:0];
                    if (late + shr_w >= len2) begin
                        st_d.seg  = SEG_SYNC;
                        st_d.qcnt = '0;
                        st_d.ext  = '0;
                        st_d.shr  = '0;
                        st_d.done = 1'b0;
                        st_d.tx   = 1'b1;
                    end else begin
                        st_d.qcnt = late;
                    end
                end
                default: st_d.seg = SEG_SYNC;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RST;
        else        st_q <= st_d;
    end

    assign tx_stb  = st_q.tx;
    assign smp_stb = st_q.smp;
    assign rx_bit  = st_q.rxb;
    assign seg     = st_q.seg;

    assert_quiet_when_bad_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (!st_q.tx && !st_q.smp && st_q.seg == SEG_SYNC));

    assert_tx_at_sync_R1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.tx |-> st_q.seg == SEG_SYNC);

    assert_smp_enters_ph2_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.smp |-> (st_q.seg == SEG_PH2 && !st_q.tx));

    assert_adjust_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (QW'(st_q.ext) <= QW'(sjw) + QW'(1)) && (QW'(st_q.shr) <= QW'(sjw) + QW'(1)));

endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
    parameter int BRP_W  = 6,
    parameter int T1_W   = 4,
    parameter int T2_W   = 3,
    parameter int SJW_W  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BRP_W-1:0] cfg_brp,
    input  logic [T1_W-1:0]  cfg_tseg1,
    input  logic [T2_W-1:0]  cfg_tseg2,
    input  logic [SJW_W-1:0] cfg_sjw,
    input  logic             cfg_triple,
    input  logic             bus_idle,
    input  logic             rx_raw,
    output logic             tq_tick,
    output logic             sample_stb,
    output logic             tx_stb,
    output logic             rx_bit,
    output logic [1:0]       seg_o,
    output logic             config_error
);
    logic bad, rx_s, rx_fall, hsync;

    assign config_error = bad;
    assign hsync        = rx_fall & bus_idle;

    can_bt_cfg_check #(.BRP_W(BRP_W), .T1_W(T1_W), .T2_W(T2_W), .SJW_W(SJW_W)) cfg_i (
        .brp(cfg_brp), .tseg1(cfg_tseg1), .tseg2(cfg_tseg2), .sjw(cfg_sjw), .bad(bad)
    );

    can_bt_rx_sync #(.STAGES(STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .rx_raw(rx_raw), .rx_s(rx_s), .rx_fall(rx_fall)
    );

    can_bt_prescaler #(.BRP_W(BRP_W)) pre_i (
        .clk(clk), .rst_n(rst_n), .brp(cfg_brp), .hold(bad), .restart(hsync),
        .tq_tick(tq_tick)
    );

    can_bt_sequencer #(.T1_W(T1_W), .T2_W(T2_W), .SJW_W(SJW_W)) seq_i (
        .clk(clk), .rst_n(rst_n), .tq_tick(tq_tick), .hold(bad), .hsync(hsync),
        .rx_s(rx_s), .rx_fall(rx_fall), .tseg1(cfg_tseg1), .tseg2(cfg_tseg2),
        .sjw(cfg_sjw), .triple(cfg_triple), .tx_stb(tx_stb), .smp_stb(sample_stb),
        .rx_bit(rx_bit), .seg(seg_o)
    );

endmodule

// File: tb/can_bit_timer_tb_top.sv
module can_bit_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] cfg_brp = '0;
    logic [3:0] cfg_tseg1 = 4'd4;
    logic [2:0] cfg_tseg2 = 3'd3;
    logic [1:0] cfg_sjw = '0;
    logic       cfg_triple = 1'b0;
    logic       bus_idle = 1'b0;
    logic       rx_raw = 1'b1;
    logic       tq_tick, sample_stb, tx_stb, rx_bit, config_error;
    logic [1:0] seg_o;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    int     exp_q[$];
    string  tag_q[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    can_bit_timer dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_brp(cfg_brp), .cfg_tseg1(cfg_tseg1),
        .cfg_tseg2(cfg_tseg2), .cfg_sjw(cfg_sjw), .cfg_triple(cfg_triple),
        .bus_idle(bus_idle), .rx_raw(rx_raw), .tq_tick(tq_tick),
        .sample_stb(sample_stb), .tx_stb(tx_stb), .rx_bit(rx_bit),
        .seg_o(seg_o), .config_error(config_error)
    );

    task automatic check_int(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic expect_val(string tag, int exp);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    task automatic score(int act);
        int    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check_int(t, act, e);
    endtask

    task automatic wait_clks(int k);
        repeat (k) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wait_tx(output int t);
        do @(negedge clk); while (tx_stb !== 1'b1);
        t = cyc;
    endtask

    task automatic wait_smp(output int t);
        do @(negedge clk); while (sample_stb !== 1'b1);
        t = cyc;
    endtask

    task automatic apply_cfg(int brp, int t1, int t2, int sjw);
        @(negedge clk);
        rst_n     = 1'b0;
        cfg_brp   = 6'(brp);
        cfg_tseg1 = 4'(t1);
        cfg_tseg2 = 3'(t2);
        cfg_sjw   = 2'(sjw);
        wait_clks(2);
        rst_n = 1'b1;
    endtask

    task automatic period_case(string tag, int exp);
        int t0, t1;
        wait_tx(t0);
        expect_val(tag, exp);
        wait_tx(t1);
        score(t1 - t0);
    endtask

    // one falling edge k clocks after the bit start, line back high 4 clocks later
    task automatic edge_case(string tag, int k, int exp);
        int t0, t1;
        wait_tx(t0);
        expect_val(tag, exp);
        wait_clks(k);
        rx_raw = 1'b0;
        wait_clks(4);
        rx_raw = 1'b1;
        wait_tx(t1);
        score(t1 - t0);
    endtask

    task automatic bad_case(string tag, int brp, int t1, int t2, int sjw, int exp_err);
        int strobes;
        apply_cfg(brp, t1, t2, sjw);
        check_int(tag, int'(config_error), exp_err);
        if (exp_err == 1) begin
            strobes = 0;
            repeat (300) begin
                @(negedge clk);
                if (tx_stb || sample_stb || seg_o != 2'd0) strobes++;
            end
            check_int({tag, " idle"}, strobes, 0);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int t0, t1;
        // R9: reset state
        wait_clks(3);
        check_int("R9 tx_stb", int'(tx_stb), 0);
        check_int("R9 sample_stb", int'(sample_stb), 0);
        check_int("R9 rx_bit", int'(rx_bit), 1);
        check_int("R9 seg_o", int'(seg_o), 0);
        rst_n = 1'b1;

        // R1: 20 clocks per bit at prescaler 0, 4/3
        period_case("R1 nominal bit", 20);
        period_case("R1 nominal bit repeat", 20);
        // R2: sample point
        wait_tx(t0);
        wait_smp(t1);
        check_int("R2 sample offset", t1 - t0, 12);
        check_int("R2 seg after sample", int'(seg_o), 2);

        // R1: shortest and longest bit
        apply_cfg(0, 3, 2, 0);
        period_case("R1 minimum bit", 16);
        apply_cfg(0, 15, 7, 3);
        period_case("R1 maximum bit", 50);

        // quantum 8 clocks, seg1 8, seg2 5, jump 2: 112 clocks
        apply_cfg(3, 7, 4, 1);
        period_case("R1 prescaled bit", 112);
        edge_case("R4 late edge q0", 8 * 1 + 1, 120);
        edge_case("R4 late edge q4 clamped", 8 * 5 + 1, 128);
        edge_case("R5 early edge q3", 8 * 12 + 1, 104);
        edge_case("R5 early edge q0 clamped", 8 * 9 + 1, 96);

        // R6: rising edge only
        wait_tx(t0);
        expect_val("R6 rising edge", 112);
        wait_clks(8 * 3 + 1);
        rx_raw = 1'b0;
        wait_tx(t1);
        rx_raw = 1'b1;
        wait_tx(t0);
        wait_clks(8 * 3 + 1);
        wait_tx(t1);
        score(t1 - t0);
        // R6: two falling edges in one bit
        wait_tx(t0);
        expect_val("R6 second edge ignored", 120);
        wait_clks(9);
        rx_raw = 1'b0;
        wait_clks(4);
        rx_raw = 1'b1;
        wait_clks(12);
        rx_raw = 1'b0;
        wait_clks(4);
        rx_raw = 1'b1;
        wait_tx(t1);
        score(t1 - t0);

        // R8: recessive glitch over the last quantum before the sample point
        rx_raw = 1'b0;
        wait_tx(t0);
        wait_tx(t0);
        cfg_triple = 1'b1;
        wait_tx(t0);
        wait_clks(65);
        rx_raw = 1'b1;
        wait_smp(t1);
        check_int("R8 triple majority", int'(rx_bit), 0);
        rx_raw = 1'b0;
        cfg_triple = 1'b0;
        wait_tx(t0);
        wait_tx(t0);
        wait_clks(65);
        rx_raw = 1'b1;
        wait_smp(t1);
        check_int("R8 single sample", int'(rx_bit), 1);
        rx_raw = 1'b1;
        wait_tx(t0);
        wait_tx(t0);

        // R7: hard synchronization while idle
        bus_idle = 1'b1;
        wait_smp(t0);
        begin
            int txs;
            txs = 0;
            rx_raw = 1'b0;
            t0 = cyc;
            do begin
                @(negedge clk);
                if (tx_stb) txs++;
            end while (sample_stb !== 1'b1);
            t1 = cyc;
            check_int("R7 hard sync sample", t1 - t0, 3 + 8 * 9);
            check_int("R7 no tx before sample", txs, 0);
        end
        rx_raw = 1'b1;
        bus_idle = 1'b0;

        // R3: legal-range decode
        bad_case("R3 tseg1 equal tseg2", 1, 3, 3, 0, 1);
        bad_case("R3 tseg1 below 3", 1, 2, 1, 0, 1);
        bad_case("R3 tseg2 1 with prescaler 0", 0, 5, 1, 0, 1);
        bad_case("R3 jump above tseg2", 1, 6, 2, 3, 1);
        bad_case("R3 tseg2 zero", 1, 5, 0, 0, 1);
        bad_case("R3 tseg2 1 with prescaler 1", 1, 5, 1, 1, 0);
        period_case("R3 permitted setting runs", 36);

        summary();
        $finish;
    end

endmodule